// File: doc/BRIEF.md
# GPIO Interrupt Channel Multiplexer

This block steers a small set of interrupt channels from a large bank of GPIO pad inputs. Each of the eight channels picks one pad by an 8-bit index, so up to 256 pads can be addressed. The selected pad is brought into the clock domain by a two-flop synchroniser and may be inverted. It is then sensed either as a level or as an edge. The result is one active-high request line per channel, which goes to a downstream interrupt controller. Falling edges and active-low levels are therefore delivered in the same polarity as their active-high counterparts.

Software programs the block through four 32-bit word registers: a trigger word, two source-select words and a filter word. The filter word is stored and read back but has no effect on the outputs. When a channel's source or trigger bits change, the channel holds its request low for a short settling window, so that a reconfiguration never shows up as an interrupt. A global enable bit gates every output.

Top module: `pad_irq_router`

## Requirements
- R1: After reset, all four registers read as zero and every interrupt output is low.
- R2: The trigger word (0x00), the low select word (0x04), the high select word (0x08) and the filter word (0x0c) read back exactly the last value written. The write takes effect at the clock edge on which the write strobe is sampled. Any other address, including unaligned ones, writes nothing and reads zero.
- R3: Channel ch takes its source index from bits [(ch mod 4)*8 +: 8] of the low select word for ch < 4, and of the high select word for ch >= 4.
- R4: With trigger bits ch, 8+ch and 16+ch all clear, output ch follows the selected pad as a level. A pad change shows on the output after the second rising clock edge.
- R5: Trigger bit 16+ch inverts channel ch, so a low pad gives a high level request.
- R6: Trigger bit ch selects edge sensing. Each rising transition of the selected pad gives exactly one one-clock high pulse, after the second rising edge. A falling transition gives nothing.
- R7: With trigger bits ch and 16+ch both set, each falling transition gives exactly one one-clock pulse, and a rising transition gives nothing.
- R8: Trigger bit 8+ch selects both-edge sensing: every transition gives one one-clock pulse. The inversion and single-edge bits of that channel are then ignored.
- R9: While trigger bit 31 is clear, every output is low. Setting it again restores the level outputs in the next cycle.
- R10: A select index at or above the number of implemented pads feeds the channel a constant zero. Such a channel reads low, or high when inverted.
- R11: Writing the filter word changes no output.
- R12: After a write that changes a channel's source index or its trigger bits ch, 8+ch or 16+ch, that channel's output stays low for the three cycles that follow the write edge. The change itself never produces an edge pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pad_in | input | NUM_PADS | Asynchronous GPIO pad levels |
| reg_addr | input | 4 | Byte address of the register word |
| reg_wdata | input | 32 | Write data |
| reg_we | input | 1 | Write strobe, one write per cycle it is high |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| irq_out | output | 8 | Active-high interrupt request per channel |

## Verification
The one-pulse-per-transition property assumes that a selected pad holds each new value for at least two clock cycles. The bench respects this: it only moves pads at least two cycles apart and waits several cycles between opposite transitions. The out-of-range and enable-gating properties assume nothing about the pads. The bench nonetheless drives every pad high while an out-of-range select is active, so a wrong index would show up. Register writes are issued only on falling clock edges and are separated by settling gaps, so each reconfiguration window is observed in isolation.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
  localparam int CH_N        = 8;
  localparam int SEL_W       = 8;
  localparam int DATA_W      = 32;
  localparam int ADDR_W      = 4;
  localparam int WORDS       = 4;
  localparam int SEL_PER_WRD = DATA_W / SEL_W;

  localparam int WI_TRIG   = 0;
  localparam int WI_SEL_LO = 1;
  localparam int WI_SEL_HI = 2;
  localparam int WI_FILT   = 3;

  localparam int EDGE_BASE = 0;
  localparam int BOTH_BASE = 8;
  localparam int INV_BASE  = 16;
  localparam int EN_BIT    = 31;

  typedef struct packed {
    logic [SEL_W-1:0] sel;
    logic             edge_en;
    logic             both;
    logic             inv;
  } ch_cfg_t;
endpackage

// File: rtl/pirq_sync.sv
module pirq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] pipe_q, pipe_d;

  always_comb begin
    pipe_d = {pipe_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= pipe_d;
  end

  assign q = pipe_q[STAGES-1];
endmodule

// File: rtl/pirq_regs.sv
module pirq_regs
  import pirq_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [DATA_W-1:0]            wdata,
  input  logic                         we,
  output logic [WORDS-1:0][DATA_W-1:0] word_q,
  output logic [DATA_W-1:0]            rdata
);
  logic [WORDS-1:0] hit;
  logic [WORDS-1:0] wr_en;

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic [DATA_W-1:0] word_d;

    always_comb begin
      hit[w]   = (addr == ADDR_W'(w * 4));
      wr_en[w] = we & hit[w];
      word_d   = wr_en[w] ? wdata : word_q[w];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) word_q[w] <= '0;
      else        word_q[w] <= word_d;
    end
  end

  always_comb begin
    rdata = '0;
    for (int w = 0; w < WORDS; w++) begin
      if (hit[w]) rdata = word_q[w];
    end
  end
endmodule

// File: rtl/pirq_channel.sv
module pirq_channel
  import pirq_pkg::*;
#(
  parameter int NUM_PADS = 200,
  parameter int SETTLE   = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PADS-1:0] pad_in,
  input  ch_cfg_t             cfg,
  input  logic                glob_en,
  output logic                irq
);
  localparam int CNT_W = $clog2(SETTLE + 1);

  logic       in_range, src, sync_lvl, cond, hit, req;
  logic       cfg_chg, quiet;
  logic       prev_q, prev_d;
  ch_cfg_t    cfg_q, cfg_d;
  logic [CNT_W-1:0] settle_q, settle_d;

  always_comb begin
    in_range = (int'(cfg.sel) < NUM_PADS);
    src      = in_range ? pad_in[cfg.sel] : 1'b0;
  end

  pirq_sync #(.STAGES(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (src),
    .q     (sync_lvl)
  );

  always_comb begin
    cond     = sync_lvl ^ (cfg.inv & ~cfg.both);
    cfg_chg  = (cfg != cfg_q);
    quiet    = cfg_chg | (settle_q != '0);
    hit      = cfg.both ? (cond ^ prev_q) : (cond & ~prev_q);
    req      = (cfg.edge_en | cfg.both) ? hit : cond;
    irq      = glob_en & ~quiet & req;
    prev_d   = cond;
    cfg_d    = cfg;
    if (cfg_chg)               settle_d = CNT_W'(SETTLE);
    else if (settle_q != '0)   settle_d = settle_q - 1'b1;
    else                       settle_d = settle_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= 1'b0;
      cfg_q    <= '0;
      settle_q <= '0;
    end else begin
      prev_q   <= prev_d;
      cfg_q    <= cfg_d;
      settle_q <= settle_d;
    end
  end
endmodule

// File: rtl/pad_irq_router.sv
module pad_irq_router
  import pirq_pkg::*;
#(
  parameter int NUM_PADS = 200
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PADS-1:0] pad_in,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [DATA_W-1:0]   reg_wdata,
  input  logic                reg_we,
  output logic [DATA_W-1:0]   reg_rdata,
  output logic [CH_N-1:0]     irq_out
);
  logic rst_meta_q, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic [WORDS-1:0][DATA_W-1:0] word_w;
  logic [DATA_W-1:0] trig_w, sel_lo_w, sel_hi_w;

  pirq_regs u_regs (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .addr   (reg_addr),
    .wdata  (reg_wdata),
    .we     (reg_we),
    .word_q (word_w),
    .rdata  (reg_rdata)
  );

  assign trig_w   = word_w[WI_TRIG];
  assign sel_lo_w = word_w[WI_SEL_LO];
  assign sel_hi_w = word_w[WI_SEL_HI];

  for (genvar ch = 0; ch < CH_N; ch++) begin : g_ch
    localparam int SRC_WORD = WI_SEL_LO + ch / SEL_PER_WRD;
    localparam int SRC_LSB  = (ch % SEL_PER_WRD) * SEL_W;
    ch_cfg_t cfg;

    always_comb begin
      cfg.sel     = word_w[SRC_WORD][SRC_LSB +: SEL_W];
      cfg.edge_en = trig_w[EDGE_BASE + ch];
      cfg.both    = trig_w[BOTH_BASE + ch];
      cfg.inv     = trig_w[INV_BASE + ch];
    end

    pirq_channel #(.NUM_PADS(NUM_PADS)) u_chan (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .pad_in  (pad_in),
      .cfg     (cfg),
      .glob_en (trig_w[EN_BIT]),
      .irq     (irq_out[ch])
    );
  end
endmodule

// File: rtl/pirq_checker.sv
module pirq_checker
  import pirq_pkg::*;
#(
  parameter int NUM_PADS = 200
) (
  input logic              clk,
  input logic              rst_n,
  input logic              we,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] trig,
  input logic [DATA_W-1:0] sel_lo,
  input logic [DATA_W-1:0] sel_hi,
  input logic [CH_N-1:0]   irq
);
  assert_gate_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !trig[EN_BIT] |-> (irq == '0));

  assert_trig_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == 4'h0) |=> (trig == $past(wdata)));

  assert_sel_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == 4'h4) |=> (sel_lo == $past(wdata)));

  for (genvar ch = 0; ch < CH_N; ch++) begin : g_chk
    logic [SEL_W-1:0] sel;
    logic             edgy, plain;
    assign sel   = (ch < SEL_PER_WRD) ? sel_lo[(ch % SEL_PER_WRD)*SEL_W +: SEL_W]
                                      : sel_hi[(ch % SEL_PER_WRD)*SEL_W +: SEL_W];
    assign edgy  = trig[EDGE_BASE + ch] | trig[BOTH_BASE + ch];
    assign plain = !trig[EDGE_BASE + ch] && !trig[BOTH_BASE + ch] && !trig[INV_BASE + ch];

    // R6 R7 R8: an edge request lasts one cycle
    assert_single_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (irq[ch] && edgy) |=> !(irq[ch] && edgy));

    assert_range_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(sel) >= NUM_PADS && plain) |-> !irq[ch]);
  end
endmodule

bind pad_irq_router pirq_checker #(.NUM_PADS(NUM_PADS)) u_chk (
  .clk    (clk),
  .rst_n  (rst_sync_n),
  .we     (reg_we),
  .addr   (reg_addr),
  .wdata  (reg_wdata),
  .trig   (trig_w),
  .sel_lo (sel_lo_w),
  .sel_hi (sel_hi_w),
  .irq    (irq_out)
);

// File: tb/pad_irq_router_test.sv
module pad_irq_router_test;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 200;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NP-1:0] pads;
  logic [3:0]    addr;
  logic [31:0]   wdata;
  logic          we;
  logic [31:0]   rdata;
  logic [7:0]    irq;

  int tests = 0;
  int fails = 0;
  logic [31:0] trig_m, slo_m, shi_m;

  always #(CLK_PERIOD/2) clk = ~clk;

  pad_irq_router #(.NUM_PADS(NP)) uut (
    .clk(clk), .rst_n(rst_n), .pad_in(pads), .reg_addr(addr),
    .reg_wdata(wdata), .reg_we(we), .reg_rdata(rdata), .irq_out(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0; addr = 4'h0;
  endtask

  task automatic rd(input string tag, input logic [3:0] a, input logic [31:0] exp);
    @(negedge clk);
    addr = a;
    #1 chk(tag, rdata, exp);
  endtask

  task automatic set_trig(input logic [31:0] v);
    trig_m = v; wr(4'h0, v); idle(4);
  endtask

  task automatic set_lo(input logic [31:0] v);
    slo_m = v; wr(4'h4, v); idle(4);
  endtask

  task automatic set_hi(input logic [31:0] v);
    shi_m = v; wr(4'h8, v); idle(4);
  endtask

  task automatic t_reset;
    rd("R1 trig", 4'h0, 0); rd("R1 sel lo", 4'h4, 0);
    rd("R1 sel hi", 4'h8, 0); rd("R1 filt", 4'hc, 0);
    chk("R1 irq", {24'h0, irq}, 0);
  endtask

  task automatic t_readback;
    wr(4'hc, 32'hA5C3_1E7F); rd("R2 filt", 4'hc, 32'hA5C3_1E7F);
    wr(4'h8, 32'h0102_0304); rd("R2 sel hi", 4'h8, 32'h0102_0304);
    wr(4'h4, 32'hFFEE_DDCC); rd("R2 sel lo", 4'h4, 32'hFFEE_DDCC);
    wr(4'h0, 32'h7F00_00FF); rd("R2 trig", 4'h0, 32'h7F00_00FF);
    wr(4'h5, 32'h1111_1111); rd("R2 unaligned no write", 4'h4, 32'hFFEE_DDCC);
    rd("R2 unaligned reads zero", 4'h5, 0);
    wr(4'h0, 0); wr(4'h4, 0); wr(4'h8, 0); wr(4'hc, 0);
    rd("R2 cleared", 4'hc, 0);
    trig_m = 0; slo_m = 0; shi_m = 0;
    idle(4);
  endtask

  task automatic t_level;
    set_lo(32'd37 << 24);
    set_trig(32'h8000_0000);
    pads[37] = 1'b1;
    @(negedge clk); chk("R4 level after one edge", {24'h0, irq}, 0);
    @(negedge clk); chk("R4 R3 level high ch3", {24'h0, irq}, 32'h08);
    pads[37] = 1'b0;
    idle(2); chk("R4 level low again", {24'h0, irq}, 0);
  endtask

  task automatic t_sel_hi;
    set_hi(32'd150 << 16);
    pads[150] = 1'b1;
    idle(2); chk("R3 ch6 from high word", {24'h0, irq}, 32'h40);
    pads[150] = 1'b0;
    idle(2); chk("R3 ch6 low", {24'h0, irq}, 0);
  endtask

  task automatic t_inv;
    set_trig(trig_m | (32'h1 << 19));
    chk("R5 inverted low pad", {24'h0, irq}, 32'h08);
    pads[37] = 1'b1;
    @(negedge clk); chk("R5 latency", {24'h0, irq}, 32'h08);
    @(negedge clk); chk("R5 inverted high pad", {24'h0, irq}, 0);
    pads[37] = 1'b0; idle(3);
    set_trig(trig_m & ~(32'h1 << 19));
  endtask

  task automatic t_rise;
    set_lo(slo_m | (32'd5 << 8));
    set_trig(trig_m | 32'h2);
    pads[5] = 1'b1;
    @(negedge clk); chk("R6 before pulse", {24'h0, irq}, 0);
    @(negedge clk); chk("R6 rising pulse", {24'h0, irq}, 32'h02);
    @(negedge clk); chk("R6 pulse one cycle", {24'h0, irq}, 0);
    idle(2);
    pads[5] = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); chk("R6 no pulse on fall", {24'h0, irq}, 0);
    end
  endtask

  task automatic t_fall;
    set_trig(trig_m | (32'h1 << 17));
    chk("R7 R12 no pulse from reconfig", {24'h0, irq}, 0);
    pads[5] = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); chk("R7 no pulse on rise", {24'h0, irq}, 0);
    end
    pads[5] = 1'b0;
    @(negedge clk); chk("R7 before pulse", {24'h0, irq}, 0);
    @(negedge clk); chk("R7 falling pulse", {24'h0, irq}, 32'h02);
    @(negedge clk); chk("R7 pulse one cycle", {24'h0, irq}, 0);
  endtask

  task automatic t_both;
    set_lo(slo_m | (32'd9 << 16));
    set_trig(trig_m | (32'h1 << 2) | (32'h1 << 10) | (32'h1 << 18));
    pads[9] = 1'b1;
    idle(2); chk("R8 pulse on rise", {24'h0, irq}, 32'h04);
    @(negedge clk); chk("R8 rise pulse ends", {24'h0, irq}, 0);
    idle(2);
    pads[9] = 1'b0;
    idle(2); chk("R8 pulse on fall", {24'h0, irq}, 32'h04);
    @(negedge clk); chk("R8 fall pulse ends", {24'h0, irq}, 0);
  endtask

  task automatic t_enable;
    pads[37] = 1'b1; idle(2);
    chk("R9 level before gating", {24'h0, irq}, 32'h08);
    trig_m = trig_m & ~32'h8000_0000; wr(4'h0, trig_m);
    chk("R9 gated off", {24'h0, irq}, 0);
    idle(3); chk("R9 stays off", {24'h0, irq}, 0);
    trig_m = trig_m | 32'h8000_0000; wr(4'h0, trig_m);
    chk("R9 restored next cycle", {24'h0, irq}, 32'h08);
    pads[37] = 1'b0; idle(3);
  endtask

  task automatic t_range;
    set_hi(shi_m | (32'd220 << 24));
    pads = '1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); chk("R10 out of range reads zero", {31'h0, irq[7]}, 0);
    end
    set_trig(trig_m | (32'h1 << 23));
    chk("R10 inverted constant zero", {31'h0, irq[7]}, 1);
    set_trig(trig_m & ~(32'h1 << 23));
    pads = '0; idle(4);
  endtask

  task automatic t_filter;
    pads[37] = 1'b1; idle(3);
    wr(4'hc, 32'h1234_5678);
    for (int i = 0; i < 3; i++) begin
      chk("R11 filter write leaves outputs", {24'h0, irq}, 32'h08);
      @(negedge clk);
    end
    rd("R11 filter stored", 4'hc, 32'h1234_5678);
  endtask

  task automatic t_cfg;
    pads[20] = 1'b1; pads[21] = 1'b1; pads[38] = 1'b1; idle(3);
    set_trig(trig_m | 32'h1);
    set_lo((slo_m & 32'hFFFF_FF00) | 32'd20);
    chk("R12 select to high pad no pulse", {31'h0, irq[0]}, 0);
    slo_m = (slo_m & 32'hFFFF_FF00) | 32'd21;
    wr(4'h4, slo_m);
    for (int i = 0; i < 5; i++) begin
      chk("R12 swap between high pads no pulse", {31'h0, irq[0]}, 0);
      @(negedge clk);
    end
    chk("R12 ch3 level high before", {31'h0, irq[3]}, 1);
    slo_m = (slo_m & 32'h00FF_FFFF) | (32'd38 << 24);
    wr(4'h4, slo_m);
    chk("R12 quiet cycle 1", {31'h0, irq[3]}, 0);
    @(negedge clk); chk("R12 quiet cycle 2", {31'h0, irq[3]}, 0);
    @(negedge clk); chk("R12 quiet cycle 3", {31'h0, irq[3]}, 0);
    @(negedge clk); chk("R12 level resumes", {31'h0, irq[3]}, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; pads = '0; addr = 4'h0; wdata = '0; we = 1'b0;
    trig_m = 0; slo_m = 0; shi_m = 0;
    idle(3);
    rst_n = 1'b1;
    idle(4);
    t_reset;
    t_readback;
    t_level;
    t_sel_hi;
    t_inv;
    t_rise;
    t_fall;
    t_both;
    t_enable;
    t_range;
    t_filter;
    t_cfg;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule